// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps three tables and combines them. A per-branch history of recent outcomes selects a 3-bit counter; this is the local guess. A shared path history selects a 2-bit counter; this is the global guess. A 2-bit chooser, indexed by the same path history, decides which guess is output. The lookup is combinational, so the answer appears in the same cycle as the branch address.

Each lookup also returns the path history that was in force when the guess was made. The block then shifts the guess into that history speculatively. When the branch resolves, the pipeline sends back the branch address, the real outcome, a mispredict flag and that history snapshot. The block trains all three tables with this information. On a mispredict it rebuilds the path history from the snapshot, with the real outcome appended.

Top module: `tourney_bp`

## Requirements
- R1: After reset every local counter holds 3, every global counter holds 1, every chooser counter holds 1 (weak preference for the local guess), and every history is zero. The first lookups therefore answer not-taken, and `pred_ghist` reads 0.
- R2: Branch addresses are word addresses. The per-branch history entry is selected by `pc[9:0] ^ pc[19:10]` and holds 10 bits. On every update, the resolved outcome is shifted in at bit 0 (taken = 1).
- R3: The 10-bit local history selects one of 1024 local counters, each 3 bits wide. The local guess is taken when the counter is 4 or more. The counter saturates at 0 and 7.
- R4: The global guess reads a 2-bit counter selected by the 12-bit path history. At lookup this is the live history; at update it is `upd_ghist`. The guess is taken when the counter is 2 or more, and the counter saturates at 0 and 3.
- R5: The chooser is a 2-bit counter selected by the same history as R4. A value of 2 or more selects the global guess; a lower value selects the local guess. It is trained only when the local and global guesses (recomputed at update from the current tables) disagree. It moves up when the global guess matched the outcome and down otherwise, saturating at 0 and 3.
- R6: `pred_taken` is a combinational function of `pred_pc` and the current state, valid in the same cycle.
- R7: A lookup with `pred_valid` returns the current path history on `pred_ghist`. At the next edge the history becomes `{hist[10:0], pred_taken}`. With neither a lookup nor a restore, the history holds.
- R8: An update with `upd_mispredict` set loads the path history with `{upd_ghist[10:0], upd_taken}`. This takes priority over a lookup in the same cycle.
- R9: When a lookup and an update fall in the same cycle, the lookup sees every table as it was before that update.
- R10: Every update trains the local and global counters with the outcome, whether or not it was mispredicted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_valid | input | 1 | Lookup request; advances the path history |
| pred_pc | input | 20 | Word address of the branch being looked up |
| pred_taken | output | 1 | Predicted direction (1 = taken) |
| pred_ghist | output | 12 | Path history snapshot for this lookup |
| upd_valid | input | 1 | Resolved branch report |
| upd_pc | input | 20 | Word address of the resolved branch |
| upd_taken | input | 1 | Resolved direction (1 = taken) |
| upd_mispredict | input | 1 | The earlier guess was wrong; restore the history |
| upd_ghist | input | 12 | Snapshot returned by the matching lookup |

## Verification
Lookup and update can fall in the same cycle. When both touch the same history entry and counters, the lookup must see the old values. When the update is a mispredict, its restore must win over the lookup's speculative shift. The bench drives both cases directly: a same-address lookup and update, and a restore raised together with a lookup. It also produces them randomly, by retiring an earlier lookup in the same cycle as a new one. Each lookup is compared against a bench model that trains only after the lookup's answer has been taken. After the forced restore, the bench also checks the history value computed by hand.

// File: rtl/tbp_pkg.sv
package tbp_pkg;

    // Saturating step of a small counter; width is fixed at 8 and callers cast.
    function automatic logic [7:0] sat_step(input logic [7:0] v, input logic up,
                                            input logic [7:0] top);
        if (up) begin
            return (v == top) ? v : v + 8'd1;
        end
        return (v == 8'd0) ? v : v - 8'd1;
    endfunction

endpackage

// File: rtl/tbp_ctr_table.sv
module tbp_ctr_table #(
    parameter int IDX_W = 10,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_msb,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up,
    output logic             cur_msb
);
    import tbp_pkg::*;

    localparam int DEPTH = 1 << IDX_W;
    localparam logic [CNT_W-1:0] MAXV = '1;
    localparam logic [CNT_W-1:0] INIT = CNT_W'((1 << (CNT_W - 1)) - 1);

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic [CNT_W-1:0] val;
    } wr_t;

    logic [CNT_W-1:0] tbl_q [DEPTH];
    logic [CNT_W-1:0] rd_val, cur_val;
    wr_t wr_d;

    assign rd_val  = tbl_q[rd_idx];
    assign cur_val = tbl_q[wr_idx];
    assign rd_msb  = rd_val[CNT_W-1];
    assign cur_msb = cur_val[CNT_W-1];

    always_comb begin
        wr_d.en  = wr_en;
        wr_d.idx = wr_idx;
        wr_d.val = CNT_W'(sat_step(8'(cur_val), wr_up, 8'(MAXV)));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tbl_q[i] <= INIT;
        end else if (wr_d.en) begin
            tbl_q[wr_d.idx] <= wr_d.val;
        end
    end

    // R10: counters saturate and only change on a write
    p_sat_high_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && cur_val == MAXV) |=> (rd_idx != $past(wr_idx)) || (rd_val == MAXV));
    p_sat_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && cur_val == '0) |=> (rd_idx != $past(wr_idx)) || (rd_val == '0));
    p_idle_stable_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !$stable(rd_idx) || $stable(rd_val));

endmodule

// File: rtl/tbp_lht.sv
module tbp_lht #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit,
    output logic [HIST_W-1:0] cur_hist
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic              en;
        logic [IDX_W-1:0]  idx;
        logic [HIST_W-1:0] val;
    } wr_t;

    logic [HIST_W-1:0] hist_q [DEPTH];
    wr_t wr_d;

    assign rd_hist  = hist_q[rd_idx];
    assign cur_hist = hist_q[wr_idx];

    always_comb begin
        wr_d.en  = wr_en;
        wr_d.idx = wr_idx;
        wr_d.val = {cur_hist[HIST_W-2:0], wr_bit};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) hist_q[i] <= '0;
        end else if (wr_d.en) begin
            hist_q[wr_d.idx] <= wr_d.val;
        end
    end

    // R2: resolved outcome enters at bit 0 of the addressed entry
    p_shift_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (rd_idx != $past(wr_idx)) ||
                  (rd_hist == {$past(cur_hist[HIST_W-2:0]), $past(wr_bit)}));

endmodule

// File: rtl/tbp_ghr.sv
module tbp_ghr #(
    parameter int GH_W = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            spec_en,
    input  logic            spec_bit,
    input  logic            fix_en,
    input  logic [GH_W-1:0] fix_snap,
    input  logic            fix_bit,
    output logic [GH_W-1:0] hist
);
    typedef struct packed {
        logic [GH_W-1:0] hist;
    } ghr_t;

    ghr_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (fix_en) begin
            st_d.hist = {fix_snap[GH_W-2:0], fix_bit};
        end else if (spec_en) begin
            st_d.hist = {st_q.hist[GH_W-2:0], spec_bit};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hist = st_q.hist;

    p_restore_r8: assert property (@(posedge clk) disable iff (!rst_n)
        fix_en |=> hist == {$past(fix_snap[GH_W-2:0]), $past(fix_bit)});
    p_spec_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (spec_en && !fix_en) |=> hist == {$past(hist[GH_W-2:0]), $past(spec_bit)});
    p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!spec_en && !fix_en) |=> $stable(hist));

endmodule

// File: rtl/tourney_bp.sv
module tourney_bp #(
    parameter int PC_W    = 20,
    parameter int LHT_AW  = 10,
    parameter int LHIST_W = 10,
    parameter int LCNT_W  = 3,
    parameter int GH_W    = 12,
    parameter int GCNT_W  = 2,
    parameter int CH_W    = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            pred_valid,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic [GH_W-1:0] pred_ghist,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken,
    input  logic            upd_mispredict,
    input  logic [GH_W-1:0] upd_ghist
);
    localparam int CHUNKS = (PC_W + LHT_AW - 1) / LHT_AW;
    localparam int FOLD_W = CHUNKS * LHT_AW;

    function automatic logic [LHT_AW-1:0] fold_pc(input logic [PC_W-1:0] pc);
        logic [FOLD_W-1:0] pad;
        logic [LHT_AW-1:0] acc;
        pad = FOLD_W'(pc);
        acc = '0;
        for (int k = 0; k < CHUNKS; k++) acc = acc ^ pad[k*LHT_AW +: LHT_AW];
        return acc;
    endfunction

    logic [LHT_AW-1:0]  p_lidx, u_lidx;
    logic [LHIST_W-1:0] p_lhist, u_lhist;
    logic p_loc, p_glb, p_sel, u_loc, u_glb, u_sel_unused;
    logic ch_wr;

    assign p_lidx = fold_pc(pred_pc);
    assign u_lidx = fold_pc(upd_pc);

    tbp_lht #(.IDX_W(LHT_AW), .HIST_W(LHIST_W)) u_lht (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(p_lidx), .rd_hist(p_lhist),
        .wr_en(upd_valid), .wr_idx(u_lidx), .wr_bit(upd_taken), .cur_hist(u_lhist)
    );

    tbp_ctr_table #(.IDX_W(LHIST_W), .CNT_W(LCNT_W)) u_lctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(p_lhist), .rd_msb(p_loc),
        .wr_en(upd_valid), .wr_idx(u_lhist), .wr_up(upd_taken), .cur_msb(u_loc)
    );

    tbp_ctr_table #(.IDX_W(GH_W), .CNT_W(GCNT_W)) u_gctr (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_ghist), .rd_msb(p_glb),
        .wr_en(upd_valid), .wr_idx(upd_ghist), .wr_up(upd_taken), .cur_msb(u_glb)
    );

    assign ch_wr = upd_valid && (u_loc != u_glb);

    tbp_ctr_table #(.IDX_W(GH_W), .CNT_W(CH_W)) u_chooser (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_ghist), .rd_msb(p_sel),
        .wr_en(ch_wr), .wr_idx(upd_ghist), .wr_up(u_glb == upd_taken),
        .cur_msb(u_sel_unused)
    );

    assign pred_taken = p_sel ? p_glb : p_loc;

    tbp_ghr #(.GH_W(GH_W)) u_ghr (
        .clk(clk), .rst_n(rst_n),
        .spec_en(pred_valid), .spec_bit(pred_taken),
        .fix_en(upd_valid && upd_mispredict), .fix_snap(upd_ghist), .fix_bit(upd_taken),
        .hist(pred_ghist)
    );

    // R5: the chooser is only written when the two guesses disagree
    p_chooser_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (upd_valid && (u_loc == u_glb) && !(pred_valid && pred_ghist == upd_ghist))
        |=> (pred_ghist != $past(upd_ghist)) || (p_sel == $past(u_sel_unused)));

endmodule

// File: tb/tourney_bp_tb.sv
`timescale 1ns/1ps
module tourney_bp_tb;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic        pred_valid = 0, upd_valid = 0, upd_taken = 0, upd_mispredict = 0;
    logic [19:0] pred_pc = '0, upd_pc = '0;
    logic [11:0] upd_ghist = '0;
    logic        pred_taken;
    logic [11:0] pred_ghist;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    tourney_bp u_dut (
        .clk(clk), .rst_n(rst_n),
        .pred_valid(pred_valid), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_ghist(pred_ghist),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken),
        .upd_mispredict(upd_mispredict), .upd_ghist(upd_ghist)
    );

    // model state
    bit [9:0]  m_lht [1024];
    bit [2:0]  m_lc  [1024];
    bit [1:0]  m_gc  [4096];
    bit [1:0]  m_ch  [4096];
    bit [11:0] m_ghr;
    bit [19:0] last_pc;
    bit [11:0] last_gh;
    bit        last_pred;
    bit        have_last = 0;

    function automatic bit [9:0] idx_of(bit [19:0] pc);
        return pc[9:0] ^ pc[19:10];
    endfunction

    function automatic bit [2:0] up3(bit [2:0] v, bit t);
        if (t) return (v == 3'd7) ? v : v + 3'd1;
        return (v == 3'd0) ? v : v - 3'd1;
    endfunction

    function automatic bit [1:0] up2(bit [1:0] v, bit t);
        if (t) return (v == 2'd3) ? v : v + 2'd1;
        return (v == 2'd0) ? v : v - 2'd1;
    endfunction

    function automatic bit model_pred(bit [19:0] pc);
        bit [9:0] lh;
        bit lp, gp;
        lh = m_lht[idx_of(pc)];
        lp = (m_lc[lh] >= 3'd4);
        gp = (m_gc[m_ghr] >= 2'd2);
        return (m_ch[m_ghr] >= 2'd2) ? gp : lp;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic step(input bit pv, input bit [19:0] ppc, input bit uv,
                        input bit [19:0] upc, input bit ut, input bit um,
                        input bit [11:0] ugh, input string tag);
        bit exp;
        bit [9:0] li, lh;
        bit lp, gp;
        exp = 0;
        @(negedge clk);
        pred_valid = pv; pred_pc = ppc; upd_valid = uv; upd_pc = upc;
        upd_taken = ut; upd_mispredict = um; upd_ghist = ugh;
        #1;
        if (pv) begin
            exp = model_pred(ppc);
            chk({tag, " pred_taken"}, int'(pred_taken), int'(exp));
            chk({tag, " pred_ghist"}, int'(pred_ghist), int'(m_ghr));
            last_pc = ppc; last_gh = m_ghr; last_pred = exp; have_last = 1;
        end
        if (uv) begin
            li = idx_of(upc);
            lh = m_lht[li];
            lp = (m_lc[lh] >= 3'd4);
            gp = (m_gc[ugh] >= 2'd2);
            if (lp != gp) m_ch[ugh] = up2(m_ch[ugh], gp == ut);
            m_lc[lh]  = up3(m_lc[lh], ut);
            m_gc[ugh] = up2(m_gc[ugh], ut);
            m_lht[li] = {lh[8:0], ut};
        end
        if (uv && um)  m_ghr = {ugh[10:0], ut};
        else if (pv)   m_ghr = {m_ghr[10:0], exp};
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R6 watchdog actual=%0d expected=%0d", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        bit [19:0] pool [8];
        int bias [8];
        int lidx;
        bit [19:0] a_pc;
        for (int i = 0; i < 1024; i++) begin m_lht[i] = '0; m_lc[i] = 3'd3; end
        for (int i = 0; i < 4096; i++) begin m_gc[i] = 2'd1; m_ch[i] = 2'd1; end
        m_ghr = '0;
        void'($urandom(32'd20240611));
        lidx = 0;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1: reset state answers not-taken, history zero
        for (int i = 0; i < 4; i++) begin
            step(1, 20'(i * 977), 0, '0, 0, 0, '0, "R1 reset");
            chk("R1 reset literal taken", int'(pred_taken), 0);
            chk("R1 reset literal ghist", int'(pred_ghist), 0);
        end

        // R5/R4: four taken updates with history 0 push chooser to global
        a_pc = 20'h00040;
        for (int i = 0; i < 4; i++) step(0, '0, 1, a_pc, 1, 0, 12'h000, "R4 train");
        step(1, a_pc, 0, '0, 0, 0, '0, "R5 chooser");
        chk("R5 chooser selects global literal", int'(pred_taken), 1);

        // R8: restore wins over a same-cycle lookup
        step(1, 20'h00123, 1, 20'h00123, 1, 1, 12'h0A5, "R8 restore+lookup");
        @(posedge clk); #1;
        chk("R8 restored history literal", int'(pred_ghist), 32'h14B);

        // R9: same-cycle lookup and update on the same entries see old values
        for (int i = 0; i < 6; i++)
            step(1, 20'h00200, 1, 20'h00200, 1, 0, m_ghr, "R9 same-cycle");

        // R3/R10: saturate local counters up then down
        for (int i = 0; i < 20; i++) step(1, 20'h00100, 1, 20'h00100, 1, 0, 12'h7FF, "R3 sat up");
        for (int i = 0; i < 20; i++) step(1, 20'h00100, 1, 20'h00100, 0, 1, 12'h7FF, "R10 sat down");

        // R2: alternating branch, local history learns the pattern
        for (int i = 0; i < 40; i++)
            step(1, 20'h0A0A5, 1, 20'h0A0A5, i[0], 0, 12'h3C3, "R2 alternating");

        // random phase: biased branches, lookups retired later
        for (int i = 0; i < 8; i++) begin
            pool[i] = 20'($urandom);
            bias[i] = int'($urandom % 9);
        end
        for (int n = 0; n < 4000; n++) begin
            bit pv, uv, ut, um;
            int k;
            bit [19:0] ppc;
            k   = int'($urandom % 8);
            pv  = ($urandom % 4) != 0;
            ppc = pool[k];
            uv  = have_last && (($urandom % 3) != 0);
            ut  = int'($urandom % 8) < bias[lidx];
            um  = (ut != last_pred);
            if (uv) have_last = 0;
            step(pv, ppc, uv, last_pc, ut, um, last_gh, "R3/R4/R5/R6/R7 random");
            if (pv) lidx = k;
        end

        @(negedge clk);
        pred_valid = 0; upd_valid = 0;
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule